// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a bank of external interrupt pins and a parent interrupt controller. The parent only understands rising edges and active-high levels. Each pin is first passed through a synchronizer. It is then converted by its own 3-bit trigger code. Active-low levels are inverted. Falling edges are inverted and turned into a one-cycle pulse. Dual-edge sources give a pulse on every transition. Each pin has an enable bit, and a disabled pin always drives its output low.

Software reaches the block through a simple register port. Writes are single-cycle strobes and reads are combinational. Enable bits are packed 32 to a word. Each pin also has its own configuration word. Rewriting a pin's trigger code can flip the normalized value of a steady input. The block masks the edge that such a flip would produce, so software can change polarity without creating a false interrupt.

Top module: `wake_irq_normalizer`

## Requirements
- R1: After reset all outputs are low, every enable word reads 0 and every configuration word reads 3'b100 (level high).
- R2: The enable bit of pin p sits in the word at byte address 0x10 + 4*(p/32), at bit p%32. A pin whose enable bit is 0 drives its output low.
- R3: The configuration word of pin p is at byte address 0x110 + 4*p. It stores write data bits [2:0] and reads them back in bits [2:0]; all other read bits are zero.
- R4: Code 3'b100 (level high): an enabled pin's output equals its input delayed by the two-flop synchronizer. An input change made just after clock edge k shows at the output just after edge k+2.
- R5: Code 3'b000 (level low): an enabled pin's output is the inverse of its synchronized input.
- R6: Code 3'b110 (rising edge): each rising input edge gives exactly one high output cycle. That cycle follows edge k+2 for an input raised just after edge k. A falling input gives no pulse.
- R7: Code 3'b010 (falling edge): each falling input edge gives exactly one high output cycle, with the same latency as R6. A rising input gives no pulse.
- R8: Code 3'b111 (dual edge): every input transition gives one high output cycle, with the same latency as R6.
- R9: In the cycle after any write to a pin's configuration word, that pin's edge output is held low. A polarity change on a steady input therefore never produces a pulse.
- R10: The undefined codes 3'b001, 3'b011 and 3'b101 keep the output low. They are still stored and read back as written.
- R11: Reads of addresses outside the enable words and the configuration words of existing pins return zero. Writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | NUM_PINS | Raw asynchronous interrupt pins |
| irq_out | output | NUM_PINS | Normalized interrupt lines toward the parent |

## Verification
The assertions check the following on every cycle and for every pin:
- a disabled pin's output stays low;
- the level modes track or invert the synchronized input;
- the rising and falling pulses never last a second cycle;
- undefined codes keep the pin quiet;
- the cycle after a configuration write carries no edge pulse.

Other behaviour needs the bench's scenarios:
- the exact latency from pin to output;
- the enable and configuration address mapping;
- read-back masking;
- ignored out-of-range writes;
- the two polarity flips that would otherwise produce a false edge (rising to falling on a low input, falling to rising on a high input).

// File: rtl/wirq_pkg.sv
package wirq_pkg;

   localparam int MAX_PINS = 256;
   localparam int EN_BASE  = 'h010;
   localparam int CFG_BASE = 'h110;

   typedef enum logic [2:0] {
      TRG_LVL_LO = 3'b000,
      TRG_FALL   = 3'b010,
      TRG_LVL_HI = 3'b100,
      TRG_RISE   = 3'b110,
      TRG_BOTH   = 3'b111
   } trig_e;

endpackage

// File: rtl/wirq_sync.sv
module wirq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wirq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/wirq_regs.sv
module wirq_regs
   import wirq_pkg::*;
#(
   parameter int NUM_PINS = 64,
   parameter int ADDR_W   = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [31:0]              wdata,
   output logic [31:0]              rdata,
   output logic [NUM_PINS-1:0]      en_q,
   output logic [NUM_PINS-1:0][2:0] cfg_q,
   output logic [NUM_PINS-1:0]      touch_q
);

   localparam int NWORDS = (NUM_PINS + 31) / 32;

   logic [NWORDS*32-1:0] en_pad;
   assign en_pad = {{(NWORDS*32-NUM_PINS){1'b0}}, en_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         touch_q <= '0;
         for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= TRG_LVL_HI;
      end else begin
         touch_q <= '0;
         if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
               if (addr == ADDR_W'(EN_BASE + 4*(p/32)))
                  en_q[p] <= wdata[p%32];
               if (addr == ADDR_W'(CFG_BASE + 4*p)) begin
                  cfg_q[p]   <= wdata[2:0];
                  touch_q[p] <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NWORDS; k++)
         if (addr == ADDR_W'(EN_BASE + 4*k)) rdata = en_pad[k*32 +: 32];
      for (int p = 0; p < NUM_PINS; p++)
         if (addr == ADDR_W'(CFG_BASE + 4*p)) rdata = {29'd0, cfg_q[p]};
   end

endmodule

// File: rtl/wirq_pin_cell.sv
module wirq_pin_cell
   import wirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       en,
   input  logic [2:0] cfg,
   input  logic       touch,
   output logic       irq
);

   logic inv, norm, hist, raw;

   // low-level and falling codes flip the pin into the active-high sense
   assign inv  = (cfg == TRG_LVL_LO) || (cfg == TRG_FALL);
   assign norm = sync_in ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= 1'b0;
      else        hist <= norm;
   end

   always_comb begin
      case (cfg)
         TRG_LVL_HI, TRG_LVL_LO: raw = norm;
         TRG_RISE,   TRG_FALL:   raw = norm & ~hist & ~touch;
         TRG_BOTH:               raw = (norm ^ hist) & ~touch;
         default:                raw = 1'b0;
      endcase
   end

   assign irq = en & raw;

endmodule

// File: rtl/wake_irq_normalizer.sv
module wake_irq_normalizer
   import wirq_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] irq_out
);

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("wake_irq_normalizer: NUM_PINS out of range");
   end
   if ((CFG_BASE + 4*NUM_PINS) > (1 << ADDR_W)) begin : g_bad_addr
      $error("wake_irq_normalizer: ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS-1:0]      en_q;
   logic [NUM_PINS-1:0][2:0] cfg_q;
   logic [NUM_PINS-1:0]      touch_q;
   logic [NUM_PINS-1:0]      sync_q;

   wirq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
   );

   wirq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .en_q(en_q), .cfg_q(cfg_q), .touch_q(touch_q)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      wirq_pin_cell cell_i (
         .clk(clk), .rst_n(rst_n), .sync_in(sync_q[p]), .en(en_q[p]),
         .cfg(cfg_q[p]), .touch(touch_q[p]), .irq(irq_out[p])
      );
   end

endmodule

// File: rtl/wirq_chk.sv
module wirq_chk #(
   parameter int NUM_PINS = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_PINS-1:0]      irq_out,
   input logic [NUM_PINS-1:0]      en_q,
   input logic [NUM_PINS-1:0][2:0] cfg_q,
   input logic [NUM_PINS-1:0]      touch_q,
   input logic [NUM_PINS-1:0]      sync_q
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0));

   // R2
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~en_q) == '0);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      // R4
      lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[p] && cfg_q[p] == 3'b100) |-> (irq_out[p] == sync_q[p]));
      // R5
      lvl_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[p] && cfg_q[p] == 3'b000) |-> (irq_out[p] == !sync_q[p]));
      // R6
      rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[p] == 3'b110 && irq_out[p]) |=> !irq_out[p]);
      // R7
      fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[p] == 3'b010 && irq_out[p]) |=> !irq_out[p]);
      // R9
      reload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (touch_q[p] && cfg_q[p][1]) |-> !irq_out[p]);
      // R10
      undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[p] == 3'b001 || cfg_q[p] == 3'b011 || cfg_q[p] == 3'b101)
         |-> !irq_out[p]);
   end

endmodule

bind wake_irq_normalizer wirq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .en_q(en_q),
   .cfg_q(cfg_q), .touch_q(touch_q), .sync_q(sync_q)
);

// File: tb/wake_irq_normalizer_tb_top.sv
`timescale 1ns/1ps
module wake_irq_normalizer_tb_top;

   localparam int NP = 64;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] irq_out;

   always #4 clk = ~clk;

   wake_irq_normalizer #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .irq_out(irq_out)
   );

   typedef struct {
      int          kind;
      int          idx;
      logic [63:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   item_t it;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;
   logic [31:0] en0 = '0;
   logic [63:0] act;

   // monitor: compares every queued expectation at the falling edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         it = q.pop_front();
         case (it.kind)
            0:       act = {63'd0, irq_out[it.idx]};
            1:       act = {32'd0, reg_rdata};
            default: act = irq_out;
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                     it.tag, it.kind, it.idx, act, it.exp);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic push(input int kind, input int idx, input logic [63:0] e, input string tag);
      item_t x;
      x.kind = kind; x.idx = idx; x.exp = e; x.tag = tag;
      q.push_back(x);
      @(negedge clk); #1;
   endtask

   task automatic chk_bit(input int p, input logic v, input string tag);
      push(0, p, {63'd0, v}, tag);
   endtask

   task automatic chk_rd(input logic [AW-1:0] a, input logic [31:0] v, input string tag);
      reg_addr = a;
      push(1, 0, {32'd0, v}, tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick(1);
      reg_wr = 1'b0;
   endtask

   function automatic logic [AW-1:0] cfga(input int p);
      return AW'(12'h110 + 4*p);
   endfunction

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      push(2, 0, 64'd0, "R1");
      chk_rd(12'h010, 32'd0, "R1");
      chk_rd(cfga(5), 32'd4, "R1");

      // R2 disabled pin stays low, enable mapping
      pin_in[3] = 1'b1; tick(2);
      chk_bit(3, 1'b0, "R2");
      en0 = 32'h8; wr(12'h010, en0);
      chk_bit(3, 1'b1, "R2");
      chk_rd(12'h010, 32'h8, "R2");
      wr(12'h014, 32'h100);
      pin_in[40] = 1'b1; tick(1);
      chk_bit(40, 1'b0, "R4");
      tick(1);
      chk_bit(40, 1'b1, "R2");

      // R4 level high latency
      pin_in[3] = 1'b0; tick(1);
      chk_bit(3, 1'b1, "R4");
      tick(1);
      chk_bit(3, 1'b0, "R4");

      // R3 config storage and read masking
      wr(cfga(7), 32'hFFFF_FFF6);
      chk_rd(cfga(7), 32'd6, "R3");

      // R5 level low
      wr(cfga(10), 32'd0);
      en0 = en0 | 32'h400; wr(12'h010, en0);
      chk_bit(10, 1'b1, "R5");
      pin_in[10] = 1'b1; tick(2);
      chk_bit(10, 1'b0, "R5");

      // R6 rising edge pulse
      en0 = en0 | 32'h80; wr(12'h010, en0);
      pin_in[7] = 1'b1; tick(1);
      chk_bit(7, 1'b0, "R6");
      tick(1);
      chk_bit(7, 1'b1, "R6");
      tick(1);
      chk_bit(7, 1'b0, "R6");
      pin_in[7] = 1'b0; tick(2);
      chk_bit(7, 1'b0, "R6");
      tick(1);
      chk_bit(7, 1'b0, "R6");

      // R9 rising->falling with low input: phantom masked
      wr(cfga(7), 32'd2);
      chk_bit(7, 1'b0, "R9");
      tick(1);
      chk_bit(7, 1'b0, "R9");
      pin_in[7] = 1'b1; tick(3);
      chk_bit(7, 1'b0, "R7");
      // R9 falling->rising with high input: phantom masked
      wr(cfga(7), 32'd6);
      chk_bit(7, 1'b0, "R9");
      tick(1);
      chk_bit(7, 1'b0, "R9");

      // R7 falling edge pulse
      wr(cfga(12), 32'd2);
      en0 = en0 | 32'h1000; wr(12'h010, en0);
      chk_bit(12, 1'b0, "R7");
      pin_in[12] = 1'b1; tick(2);
      chk_bit(12, 1'b0, "R7");
      pin_in[12] = 1'b0; tick(1);
      chk_bit(12, 1'b0, "R7");
      tick(1);
      chk_bit(12, 1'b1, "R7");
      tick(1);
      chk_bit(12, 1'b0, "R7");

      // R8 dual edge
      wr(cfga(20), 32'd7);
      en0 = en0 | 32'h0010_0000; wr(12'h010, en0);
      pin_in[20] = 1'b1; tick(2);
      chk_bit(20, 1'b1, "R8");
      tick(1);
      chk_bit(20, 1'b0, "R8");
      pin_in[20] = 1'b0; tick(2);
      chk_bit(20, 1'b1, "R8");
      tick(1);
      chk_bit(20, 1'b0, "R8");

      // R10 undefined codes
      wr(cfga(25), 32'd1);
      en0 = en0 | 32'h0200_0000; wr(12'h010, en0);
      pin_in[25] = 1'b1; tick(2);
      chk_bit(25, 1'b0, "R10");
      tick(1);
      chk_bit(25, 1'b0, "R10");
      wr(cfga(25), 32'd5);
      chk_bit(25, 1'b0, "R10");
      chk_rd(cfga(25), 32'd5, "R10");
      wr(cfga(25), 32'd3);
      pin_in[25] = 1'b0; tick(2);
      chk_bit(25, 1'b0, "R10");

      // R11 unmapped addresses
      wr(12'h018, 32'hFFFF_FFFF);
      chk_rd(12'h018, 32'd0, "R11");
      chk_rd(12'h010, en0, "R11");
      wr(12'h210, 32'd7);
      chk_rd(12'h210, 32'd0, "R11");
      wr(12'h000, 32'hFFFF_FFFF);
      chk_rd(12'h000, 32'd0, "R11");
      chk_rd(12'h014, 32'h100, "R11");
      chk_bit(40, 1'b1, "R11");
      chk_bit(10, 1'b0, "R11");

      tick(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL all watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule